// File: doc/BRIEF.md
# MicroWire Serial Master Controller

This block is a half-duplex serial master with a register interface. It drives up to four chip selects. A host loads a left-justified transmit word and selects a device. It then writes one command word that gives a write bit count and a read bit count, and starts the transfer. The shift engine sends the write bits MSB first. Any read bits follow under the same chip select, and they are collected right-justified into the receive register. Status bits in the command register report busy and read-data-ready.

Each chip select has its own 6-bit mode field. The field sets the edge on which output changes, the edge on which input is sampled, the active level of the select, a second-stage clock divider, and an optional wait for the data input to go low before shifting starts. The serial clock idles low. It advances only on cycles where the external prescaler enable is high.

Top module: `mwire_master`

## Requirements
- R1: After reset all chip selects are inactive (high with the default mode), the serial clock and data output are low, and the command/status register (index 1) reads 0.
- R2: A write to index 1 with bit 12 set drives chip select bits 11:10 active and all others inactive. A write with bit 12 clear releases every select.
- R3: Mode bit 2 of a select makes its active level high. Setup register index 2 holds selects 0 and 1 in bits 5:0 and 11:6, and index 3 holds selects 2 and 3 in the same way.
- R4: With start (bit 13) and write count bits 9:5 equal to N (1..16), N clock pulses are generated and transmit bits 15 down to 16-N are sent in that order.
- R5: With read count bits 4:0 equal to M, M bits are received. The last bit received lands in bit 0 of index 0, upper bits read 0, and status bit 15 is set when the transfer ends.
- R6: Status bit 14 (busy) reads 1 from the cycle after a start until the last clock edge, then reads 0.
- R7: Mode bit 1 set changes output on rising clock edges (clear: on falling edges). Mode bit 0 set samples input on falling edges (clear: on rising edges).
- R8: Mode bits 4:3 equal to 0, 1 or 2 give a serial clock period of 2, 4 or 8 enabled cycles.
- R9: With mode bit 5 set, no clock edge is generated after start while the data input is high. Shifting begins once it is low.
- R10: A command write while busy is ignored: chip selects, stored counts and the transfer in progress are unchanged, and no new transfer starts.
- R11: Reading index 0 clears status bit 15.
- R12: When both counts are nonzero, the write bits go first and the read bits follow in the same transfer, so N+M clock pulses are generated in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_en_i | input | 1 | Prescaler enable tick |
| reg_addr_i | input | 3 | Register word index |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from index |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 4 | Chip selects, level per mode field |

## Verification
A wrong edge counter or bit index shows up at the ports within one transfer: the serial clock gives the wrong pulse count, or the slave model captures a shifted bit pattern. A bad engine state or a stale mode latch shows as busy stuck high in the status register, or as clock edges during the ready wait, within a few enable ticks of the start. Chip-select and ready-flag faults show on the cs_o pins, or in bit 15 of the next status read.

// File: rtl/mwire_pkg.sv
package mwire_pkg;
  typedef struct packed {
    logic       chk_rdy;
    logic [1:0] div_sel;
    logic       cs_hi;
    logic       drv_rise;
    logic       smp_fall;
  } mode_t;

  localparam int unsigned MODE_W     = $bits(mode_t);
  localparam int unsigned CMD_RDY    = 15;
  localparam int unsigned CMD_BUSY   = 14;
  localparam int unsigned CMD_START  = 13;
  localparam int unsigned CMD_ASSERT = 12;
  localparam int unsigned CMD_CS_LO  = 10;
  localparam int unsigned CMD_WB_LO  = 5;
  localparam int unsigned CMD_RB_LO  = 0;
  localparam int unsigned CMD_CNT_W  = 5;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_WAIT  = 2'd1,
    ENG_SHIFT = 2'd2
  } eng_state_e;

  // enable ticks per serial clock half period
  function automatic logic [2:0] half_len(logic [1:0] sel);
    case (sel)
      2'd0:    half_len = 3'd1;
      2'd1:    half_len = 3'd2;
      default: half_len = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/mwire_regs.sv
module mwire_regs
  import mwire_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 busy_i,
  input  logic                 rx_done_i,
  input  logic [DATA_W-1:0]    rxd_i,
  output logic                 start_o,
  output mode_t                mode_o,
  output logic [CMD_CNT_W-1:0] wbits_o,
  output logic [CMD_CNT_W-1:0] rbits_o,
  output logic [DATA_W-1:0]    txd_o,
  output logic [NUM_CS-1:0]    cs_o,
  output logic [NUM_CS-1:0]    cs_hi_o,
  output logic                 rdy_o
);
  localparam int unsigned CS_W  = $clog2(NUM_CS);
  localparam int unsigned SET_N = (NUM_CS + 1) / 2;
  localparam int unsigned FLD_W = 2 * MODE_W;
  localparam int unsigned SET_BASE = 2;

  logic [FLD_W-1:0]     setup_q [SET_N];
  logic [DATA_W-1:0]    tx_q;
  logic [CS_W-1:0]      cs_sel_q;
  logic                 cs_on_q;
  logic [CMD_CNT_W-1:0] wcnt_q, rcnt_q;
  logic                 rdy_q;
  mode_t                mode_vec [NUM_CS];

  logic cmd_wr, rx_rd;
  logic [CS_W-1:0] cmd_cs;
  assign cmd_wr = reg_wr_i && (reg_addr_i == ADDR_W'(1)) && !busy_i;
  assign rx_rd  = reg_rd_i && (reg_addr_i == ADDR_W'(0));
  assign cmd_cs = reg_wdata_i[CMD_CS_LO +: CS_W];

  assign wbits_o = reg_wdata_i[CMD_WB_LO +: CMD_CNT_W];
  assign rbits_o = reg_wdata_i[CMD_RB_LO +: CMD_CNT_W];
  assign start_o = cmd_wr && reg_wdata_i[CMD_START] && ((wbits_o != '0) || (rbits_o != '0));
  assign mode_o  = mode_vec[cmd_cs];
  assign txd_o   = tx_q;
  assign rdy_o   = rdy_q;

  for (genvar s = 0; s < SET_N; s++) begin : g_setup
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) setup_q[s] <= '0;
      else if (reg_wr_i && reg_addr_i == ADDR_W'(SET_BASE + s))
        setup_q[s] <= reg_wdata_i[FLD_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign mode_vec[i] = mode_t'(setup_q[i/2][(i%2)*MODE_W +: MODE_W]);
    assign cs_hi_o[i]  = mode_vec[i].cs_hi;
    assign cs_o[i]     = ~((cs_on_q && cs_sel_q == CS_W'(i)) ^ mode_vec[i].cs_hi);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      cs_sel_q <= '0;
      cs_on_q  <= 1'b0;
      wcnt_q   <= '0;
      rcnt_q   <= '0;
      rdy_q    <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == ADDR_W'(0)) tx_q <= reg_wdata_i;
      if (cmd_wr) begin
        cs_sel_q <= cmd_cs;
        cs_on_q  <= reg_wdata_i[CMD_ASSERT];
        wcnt_q   <= wbits_o;
        rcnt_q   <= rbits_o;
      end
      // completion wins over a same-cycle clear
      if (rx_done_i)              rdy_q <= 1'b1;
      else if (rx_rd || start_o)  rdy_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(0)) reg_rdata_o = rxd_i;
    else if (reg_addr_i == ADDR_W'(1))
      reg_rdata_o = {rdy_q, busy_i, 1'b0, cs_on_q, 2'(cs_sel_q), wcnt_q, rcnt_q};
    else
      for (int s = 0; s < SET_N; s++)
        if (reg_addr_i == ADDR_W'(SET_BASE + s)) reg_rdata_o = DATA_W'(setup_q[s]);
  end
endmodule

// File: rtl/mwire_shift.sv
module mwire_shift
  import mwire_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_en_i,
  input  logic                 start_i,
  input  mode_t                mode_i,
  input  logic [CMD_CNT_W-1:0] wbits_i,
  input  logic [CMD_CNT_W-1:0] rbits_i,
  input  logic [DATA_W-1:0]    txd_i,
  input  logic                 sdi_i,
  output logic                 busy_o,
  output logic                 wait_o,
  output logic                 done_o,
  output logic                 rx_done_o,
  output logic [DATA_W-1:0]    rxd_o,
  output logic                 sclk_o,
  output logic                 sdo_o
);
  localparam int unsigned CNT_W  = $clog2(DATA_W) + 1;
  localparam int unsigned EDGE_W = CNT_W + 1;

  eng_state_e         state_q;
  mode_t              mode_q;
  logic [CNT_W-1:0]   wb_q;
  logic [EDGE_W-1:0]  tot_q, edge_q, last_edge;
  logic [2:0]         dcnt_q;
  logic [DATA_W-1:0]  sh_q, rx_q;
  logic               rd_q, sclk_q, sdo_q, done_q;

  logic [CNT_W-1:0]   cw, cr, bitn;
  logic               rising, tick;

  assign cw = (CNT_W'(wbits_i) > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : CNT_W'(wbits_i);
  assign cr = (CNT_W'(rbits_i) > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : CNT_W'(rbits_i);
  assign last_edge = EDGE_W'({tot_q[EDGE_W-2:0], 1'b0} - EDGE_W'(1));
  assign bitn   = edge_q[EDGE_W-1:1];
  assign rising = !edge_q[0];
  assign tick   = sclk_en_i && (dcnt_q == half_len(mode_q.div_sel) - 3'd1);

  assign busy_o    = (state_q != ENG_IDLE);
  assign wait_o    = (state_q == ENG_WAIT);
  assign done_o    = done_q;
  assign rx_done_o = done_q && rd_q;
  assign rxd_o     = rx_q;
  assign sclk_o    = sclk_q;
  assign sdo_o     = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      mode_q  <= '0;
      wb_q    <= '0;
      tot_q   <= '0;
      edge_q  <= '0;
      dcnt_q  <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      rd_q    <= 1'b0;
      sclk_q  <= 1'b0;
      sdo_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ENG_IDLE: if (start_i) begin
          mode_q <= mode_i;
          wb_q   <= cw;
          tot_q  <= EDGE_W'(cw) + EDGE_W'(cr);
          edge_q <= '0;
          dcnt_q <= '0;
          rx_q   <= '0;
          rd_q   <= (cr != '0);
          sclk_q <= 1'b0;
          // falling-edge drive needs the first bit set up before the first rise
          if (cw != '0 && !mode_i.drv_rise) begin
            sdo_q <= txd_i[DATA_W-1];
            sh_q  <= txd_i << 1;
          end else begin
            sdo_q <= 1'b0;
            sh_q  <= txd_i;
          end
          state_q <= mode_i.chk_rdy ? ENG_WAIT : ENG_SHIFT;
        end
        ENG_WAIT: if (!sdi_i) state_q <= ENG_SHIFT;
        ENG_SHIFT: if (sclk_en_i) begin
          if (!tick) dcnt_q <= dcnt_q + 3'd1;
          else begin
            dcnt_q <= '0;
            sclk_q <= rising;
            if (mode_q.drv_rise && rising) begin
              if (bitn < wb_q) begin
                sdo_q <= sh_q[DATA_W-1];
                sh_q  <= sh_q << 1;
              end else sdo_q <= 1'b0;
            end
            if (!mode_q.drv_rise && !rising) begin
              if (EDGE_W'(bitn) + EDGE_W'(1) < EDGE_W'(wb_q)) begin
                sdo_q <= sh_q[DATA_W-1];
                sh_q  <= sh_q << 1;
              end else sdo_q <= 1'b0;
            end
            if ((rising != mode_q.smp_fall) && (bitn >= wb_q))
              rx_q <= {rx_q[DATA_W-2:0], sdi_i};
            if (edge_q == last_edge) begin
              state_q <= ENG_IDLE;
              done_q  <= 1'b1;
            end else edge_q <= edge_q + EDGE_W'(1);
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwire_master.sv
module mwire_master
  import mwire_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sclk_o,
  output logic [NUM_CS-1:0] cs_o
);
  logic                 eng_busy, eng_wait, eng_done, eng_rx_done, eng_start, rx_rdy;
  mode_t                start_mode;
  logic [CMD_CNT_W-1:0] start_wb, start_rb;
  logic [DATA_W-1:0]    tx_word, rx_word;
  logic [NUM_CS-1:0]    cs_hi_vec;

  mwire_regs #(.DATA_W(DATA_W), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .busy_i      (eng_busy),
    .rx_done_i   (eng_rx_done),
    .rxd_i       (rx_word),
    .start_o     (eng_start),
    .mode_o      (start_mode),
    .wbits_o     (start_wb),
    .rbits_o     (start_rb),
    .txd_o       (tx_word),
    .cs_o        (cs_o),
    .cs_hi_o     (cs_hi_vec),
    .rdy_o       (rx_rdy)
  );

  mwire_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_en_i (sclk_en_i),
    .start_i   (eng_start),
    .mode_i    (start_mode),
    .wbits_i   (start_wb),
    .rbits_i   (start_rb),
    .txd_i     (tx_word),
    .sdi_i     (sdi_i),
    .busy_o    (eng_busy),
    .wait_o    (eng_wait),
    .done_o    (eng_done),
    .rx_done_o (eng_rx_done),
    .rxd_o     (rx_word),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o)
  );
endmodule

// File: rtl/mwire_master_chk.sv
module mwire_master_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_en_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              sdi_i,
  input logic              sclk_o,
  input logic [NUM_CS-1:0] cs_o,
  input logic [NUM_CS-1:0] cs_hi_vec,
  input logic              eng_busy,
  input logic              eng_wait,
  input logic              eng_done,
  input logic              rx_rdy
);
  logic cmd_wr, go_req;
  assign cmd_wr = reg_wr_i && reg_addr_i == ADDR_W'(1);
  assign go_req = cmd_wr && reg_wdata_i[13] && (reg_wdata_i[9:0] != '0);

  // R2
  cs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~(cs_o ^ cs_hi_vec)));

  // R6
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_req && !eng_busy |=> eng_busy);

  // R4
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy |-> !sclk_o);

  // R8
  sclk_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> $past(sclk_en_i));

  // R9
  rdy_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_wait && sdi_i |=> $stable(sclk_o) && eng_wait);

  // R10
  busy_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy && cmd_wr |=> $stable(cs_o) && eng_busy);

  // R11
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i == ADDR_W'(0) && !eng_done |=> !rx_rdy);
endmodule

bind mwire_master mwire_master_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sclk_en_i   (sclk_en_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wdata_i (reg_wdata_i),
  .sdi_i       (sdi_i),
  .sclk_o      (sclk_o),
  .cs_o        (cs_o),
  .cs_hi_vec   (cs_hi_vec),
  .eng_busy    (eng_busy),
  .eng_wait    (eng_wait),
  .eng_done    (eng_done),
  .rx_rdy      (rx_rdy)
);

// File: tb/sim_mwire_master.sv
`timescale 1ns/1ps
module sim_mwire_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_en = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sdi, sdo, sclk;
  logic [3:0]  cs;

  int n_chk = 0, n_bad = 0;

  // slave model state
  logic [31:0] resp = '0;
  logic [5:0]  smode = '0;
  logic        slv_rst = 1'b0, force_hi = 1'b0;
  logic        cap [64];
  int          cap_n = 0, k = 0, rise_n = 0;
  longint      t_r1 = 0, t_r2 = 0;
  logic [11:0] shadow [2];

  always #5 clk = ~clk;

  assign sdi = force_hi | ((k < 32) ? resp[5'(31 - k)] : 1'b0);

  mwire_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_en_i(sclk_en),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sdi_i(sdi), .sdo_o(sdo), .sclk_o(sclk), .cs_o(cs)
  );

  // captures only on edges where the master holds its output steady
  always @(posedge sclk or negedge sclk or posedge slv_rst) begin
    if (slv_rst) begin
      cap_n = 0; k = 0; rise_n = 0;
    end else if (sclk) begin
      rise_n++;
      if (rise_n == 1) t_r1 = $time;
      if (rise_n == 2) t_r2 = $time;
      if (!smode[1] && cap_n < 64) begin cap[cap_n] = sdo; cap_n++; end
      if (smode[0]) k++;
    end else begin
      if (smode[1] && cap_n < 64) begin cap[cap_n] = sdo; cap_n++; end
      if (!smode[0]) k++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    for (int i = 0; i < 3000; i++) begin
      reg_read(3'd1, st);
      if (!st[14]) return;
    end
    chk("R6 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic set_mode(input int c, input logic [5:0] m);
    shadow[c/2][(c%2)*6 +: 6] = m;
    reg_write(3'(2 + c/2), {4'h0, shadow[c/2]});
  endtask

  function automatic logic [15:0] exp_rx(input logic [31:0] r, input int wb, input int rb, input logic sf);
    logic [15:0] v = '0;
    for (int j = wb; j < wb + rb; j++) begin
      int kk = sf ? j + 1 : j;
      v = {v[14:0], (kk < 32) ? r[5'(31 - kk)] : 1'b0};
    end
    return v;
  endfunction

  task automatic launch(input int c, input logic [5:0] m, input logic [15:0] tx,
                        input int wb, input int rb, input logic [31:0] r);
    logic [15:0] st;
    smode = m; resp = r;
    set_mode(c, m);
    reg_write(3'd0, tx);
    @(negedge clk); slv_rst = 1'b1; #1 slv_rst = 1'b0;
    reg_write(3'd1, {3'b001, 1'b1, 2'(c), 5'(wb), 5'(rb)});
    reg_read(3'd1, st);
    chk("R6 busy after start", 32'(st[14]), 32'd1);
  endtask

  task automatic check_tx(input string tag, input logic [15:0] tx, input int wb);
    logic [15:0] got = '0, exp = '0;
    for (int i = 0; i < wb; i++) begin
      got[15 - i] = cap[i];
      exp[15 - i] = tx[15 - i];
    end
    chk(tag, 32'(got), 32'(exp));
  endtask

  task automatic t_reset();
    logic [15:0] st;
    chk("R1 cs idle", 32'(cs), 32'hF);
    chk("R1 sclk/sdo low", {30'd0, sclk, sdo}, 32'd0);
    reg_read(3'd1, st);
    chk("R1 status zero", 32'(st), 32'd0);
  endtask

  task automatic t_select();
    reg_write(3'd1, 16'h1400);               // assert, select 1
    chk("R2 select 1 active", 32'(cs), 32'hD);
    set_mode(3, 6'b000100);                  // select 3 active high
    chk("R3 select 3 idle low", 32'(cs), 32'h5);
    reg_write(3'd1, 16'h1C00);
    chk("R3 select 3 active high", 32'(cs), 32'hF);
    reg_write(3'd1, 16'h0C00);
    chk("R2 release", 32'(cs), 32'h7);
  endtask

  task automatic t_write(input logic [5:0] m, input logic [15:0] tx, input int wb, input string tag);
    launch(0, m, tx, wb, 0, 32'h0);
    wait_idle();
    chk({tag, " pulses"}, rise_n, wb);
    check_tx({tag, " bits"}, tx, wb);
  endtask

  task automatic t_read(input int c, input logic [5:0] m, input int rb, input logic [31:0] r, input string tag);
    logic [15:0] st, v;
    launch(c, m, 16'h0, 0, rb, r);
    wait_idle();
    chk({tag, " pulses"}, rise_n, rb);
    reg_read(3'd1, st);
    chk("R5 ready set", 32'(st[15]), 32'd1);
    reg_read(3'd0, v);
    chk({tag, " data"}, 32'(v), 32'(exp_rx(r, 0, rb, m[0])));
    reg_read(3'd1, st);
    chk("R11 ready cleared by read", 32'(st[15]), 32'd0);
  endtask

  task automatic t_div(input logic [1:0] d, input int period);
    launch(0, {1'b0, d, 3'b000}, 16'hA5A5, 4, 0, 32'h0);
    wait_idle();
    chk("R8 clock period", 32'((t_r2 - t_r1) / 10), 32'(period));
  endtask

  task automatic t_ready();
    logic [15:0] st;
    force_hi = 1'b1;
    launch(0, 6'b100000, 16'hC300, 8, 0, 32'h0);
    repeat (30) @(negedge clk);
    chk("R9 no edges while input high", rise_n, 0);
    reg_read(3'd1, st);
    chk("R9 busy while waiting", 32'(st[14]), 32'd1);
    force_hi = 1'b0;
    wait_idle();
    chk("R9 shifts after input low", rise_n, 8);
    check_tx("R9 bits", 16'hC300, 8);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] st;
    launch(0, 6'b010000, 16'h8001, 16, 0, 32'h0);
    repeat (10) @(negedge clk);
    reg_write(3'd1, 16'h3A42);               // start on select 2 while busy
    chk("R10 selects unchanged", 32'(cs), 32'h6);
    wait_idle();
    chk("R10 single transfer", rise_n, 16);
    repeat (5) @(negedge clk);
    reg_read(3'd1, st);
    chk("R10 no second start", 32'(st[14]), 32'd0);
    chk("R10 fields kept", 32'(st[11:0]), 32'h200);
  endtask

  task automatic t_combo();
    logic [15:0] v;
    logic [31:0] r = 32'h3C96_F00F;
    launch(2, 6'b000000, 16'hB700, 8, 8, r);
    wait_idle();
    chk("R12 total pulses", rise_n, 16);
    check_tx("R12 write part", 16'hB700, 8);
    reg_read(3'd0, v);
    chk("R12 read part", 32'(v), 32'(exp_rx(r, 8, 8, 1'b0)));
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    shadow[0] = '0; shadow[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_write(6'b000000, 16'hA5C3, 16, "R4 full word");
    t_write(6'b000000, 16'hD000, 4, "R4 short word");
    t_write(6'b000010, 16'h6B00, 7, "R7 rising drive");
    t_read(0, 6'b000000, 16, 32'hC3A5_5A3C, "R5 rising sample");
    t_read(2, 6'b000001, 5, 32'h9E00_0000, "R7 falling sample");
    t_read(0, 6'b000000, 1, 32'h8000_0000, "R5 single bit");
    t_div(2'd0, 2);
    t_div(2'd1, 4);
    t_div(2'd2, 8);
    t_ready();
    t_busy_ignore();
    t_combo();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule